// File: doc/BRIEF.md
# Edge-Selectable Input Capture Unit

This unit watches one external input and, when a chosen event occurs on it, copies the value of a free-running timer into a capture register and raises a sticky flag. A 4-bit mode code picks the event. It can be every falling edge, every rising edge, every fourth rising edge or every sixteenth rising edge. Code zero switches the unit off and clears all its state. Every other code leaves it idle.

The input is asynchronous. It passes through a two-flop synchroniser, and one more register then finds its edges. A change on the pin is acted on at the third rising clock edge after it. The timer value stored is the one present at that third edge. The flag stays set until the flag-clear input is raised. A later capture replaces the stored value whether or not the flag is set.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, cap_value is 0 and cap_flag is 0.
- R2: With mode 4'b0100, every falling edge of cap_pin captures. If the pin changes between clock edges E0 and E1, cap_value takes the timer value present at edge E3 (two edges after E1), and cap_flag sets at E3.
- R3: With mode 4'b0101, every rising edge of cap_pin captures, with the same timing as R2.
- R4: With mode 4'b0110, a capture happens on every 4th rising edge counted since the prescaler was last cleared. Rising edges in between leave cap_value and cap_flag unchanged.
- R5: With mode 4'b0111, a capture happens on every 16th rising edge counted since the prescaler was last cleared.
- R6: With mode 4'b0000, cap_flag and cap_value go to 0, the prescaler clears, and no capture happens.
- R7: Any mode code other than 4'b0000 and 4'b0100..4'b0111 causes no capture. cap_value and cap_flag keep their values, and the prescaler stays cleared.
- R8: The prescaler clears whenever the mode code differs from its value on the previous clock. Edges counted before the change do not count toward the next capture.
- R9: cap_flag stays set until flag_clr is high at a clock edge. If a capture happens at the same edge, the capture wins.
- R10: A capture while cap_flag is already set overwrites cap_value with the new timer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | Event select code |
| cap_pin | input | 1 | Asynchronous input being watched |
| timer_val | input | 16 | Free-running timer value |
| flag_clr | input | 1 | Clears cap_flag |
| cap_value | output | 16 | Latched timer value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
The unit is driven with trains of clean pulses of different lengths under each capture code. Edge counts are chosen to fall just below, at and just past the prescale limits of 4 and 16, which separates an off-by-one prescaler from a correct one. Falling-edge runs and rising-edge runs show whether the polarity decode is right. Runs under unused codes show that such codes capture nothing. Directed tests then cover these cases:
- a mode switch part-way through a count, which shows whether stale edges are discarded
- overwrite while the flag is set, and the flag clear
- switching off after a capture

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] mode,
  input  logic          cap_pin,
  input  logic [TW-1:0] timer_val,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_value,
  output logic          cap_flag
);
  localparam logic [MW-1:0] M_OFF  = MW'(0);
  localparam logic [MW-1:0] M_FALL = MW'(4);
  localparam logic [MW-1:0] M_RISE = MW'(5);
  localparam logic [MW-1:0] M_DIV4 = MW'(6);
  localparam logic [MW-1:0] M_DIV16 = MW'(7);
  localparam int CW = 4;

  logic          s1, s2, prev;
  logic [MW-1:0] mode_q;
  logic [CW-1:0] cnt;

  wire off       = (mode == M_OFF);
  wire chg       = (mode != mode_q);
  wire rise      = s2 & ~prev;
  wire fall      = ~s2 & prev;
  wire prescaled = (mode == M_DIV4) || (mode == M_DIV16);
  wire [CW-1:0] lim = (mode == M_DIV4) ? CW'(3) : CW'(15);
  wire hit       = prescaled & rise & ~chg & (cnt == lim);
  wire take      = ((mode == M_FALL) & fall) | ((mode == M_RISE) & rise) | hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      prev <= 1'b0;
      mode_q <= M_OFF;
      cnt <= '0;
      cap_value <= '0;
      cap_flag <= 1'b0;
    end else begin
      s1 <= cap_pin;
      s2 <= s1;
      prev <= s2;
      mode_q <= mode;
      if (off) begin
        cnt <= '0;
        cap_value <= '0;
        cap_flag <= 1'b0;
      end else begin
        if (chg || !prescaled) cnt <= '0;
        else if (rise) cnt <= hit ? '0 : cnt + 1'b1;
        if (take) cap_value <= timer_val;
        if (take) cap_flag <= 1'b1;
        else if (flag_clr) cap_flag <= 1'b0;
      end
    end
  end
endmodule

module edge_capture_unit_chk #(
  parameter int TW = 16,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [MW-1:0] mode,
  input logic          flag_clr,
  input logic [TW-1:0] cap_value,
  input logic          cap_flag
);
  // R6
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == '0) |=> (!cap_flag && cap_value == '0));
  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag && !flag_clr && mode != '0) |=> cap_flag);
  // R9
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cap_flag) |-> ($past(flag_clr) || $past(mode) == '0));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != '0 && mode[3:2] != 2'b01) |=> $stable(cap_value));
  // R2
  flag_rise_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cap_flag) |-> ($past(mode[3:2]) == 2'b01));
  // R10
  value_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($changed(cap_value) && $past(mode) != '0) |-> cap_flag);
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.TW(TW), .MW(MW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .flag_clr(flag_clr),
  .cap_value(cap_value), .cap_flag(cap_flag));

// File: tb/edge_capture_unit_tb_top.sv
module edge_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        cap_pin = 1'b0;
  logic [15:0] timer_val = 16'h1000;
  logic        flag_clr = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag;

  int errors = 0;
  int checks = 0;
  logic [3:0]  cur_mode = 4'd0;
  int          pcount = 0;
  logic [15:0] exp_val = '0;
  logic        exp_flag = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) timer_val <= timer_val + 16'd1;

  edge_capture_unit dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cap_pin(cap_pin),
    .timer_val(timer_val), .flag_clr(flag_clr),
    .cap_value(cap_value), .cap_flag(cap_flag));

  localparam int NV = 10;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0101, 8'd3}, {4'b0100, 8'd2}, {4'b0110, 8'd3}, {4'b0110, 8'd4},
    {4'b0110, 8'd9}, {4'b0111, 8'd15}, {4'b0111, 8'd16}, {4'b0111, 8'd17},
    {4'b0011, 8'd3}, {4'b1101, 8'd2}};

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic [3:0] m);
    @(negedge clk);
    mode = m;
    if (m != cur_mode) pcount = 0;
    if (m == 4'd0) begin exp_flag = 1'b0; exp_val = '0; end
    cur_mode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic model_cap(input logic [15:0] t);
    exp_val = t + 16'd2;
    exp_flag = 1'b1;
  endtask

  task automatic pulse();
    logic [15:0] t;
    @(negedge clk);
    cap_pin = 1'b1;
    t = timer_val;
    if (cur_mode == 4'b0101) model_cap(t);
    else if (cur_mode == 4'b0110 || cur_mode == 4'b0111) begin
      pcount++;
      if (pcount == ((cur_mode == 4'b0110) ? 4 : 16)) begin
        pcount = 0;
        model_cap(t);
      end
    end
    repeat (4) @(negedge clk);
    cap_pin = 1'b0;
    t = timer_val;
    if (cur_mode == 4'b0100) model_cap(t);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 value", cap_value, 16'd0);
    check("R1 flag", {15'd0, cap_flag}, 16'd0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R7 vectors
    for (int i = 0; i < NV; i++) begin
      set_mode(4'd0);
      set_mode(VEC[i][11:8]);
      for (int p = 0; p < int'(VEC[i][7:0]); p++) pulse();
      check($sformatf("R2-5/R7 vec%0d value", i), cap_value, exp_val);
      check($sformatf("R2-5/R7 vec%0d flag", i), {15'd0, cap_flag}, {15'd0, exp_flag});
    end

    // R8 mode change clears prescaler
    set_mode(4'd0);
    set_mode(4'b0110);
    pulse(); pulse();
    set_mode(4'b0111);
    set_mode(4'b0110);
    pulse(); pulse();
    check("R8 no capture after change", {15'd0, cap_flag}, 16'd0);
    pulse(); pulse();
    check("R8 capture on fourth fresh edge flag", {15'd0, cap_flag}, 16'd1);
    check("R8 capture value", cap_value, exp_val);

    // R10 overwrite while set
    set_mode(4'b0101);
    pulse();
    check("R10 first value", cap_value, exp_val);
    pulse();
    check("R10 overwritten value", cap_value, exp_val);
    check("R10 flag still set", {15'd0, cap_flag}, 16'd1);

    // R7 unused code holds value and flag
    set_mode(4'b1100);
    pulse(); pulse();
    check("R7 value held", cap_value, exp_val);
    check("R7 flag held", {15'd0, cap_flag}, 16'd1);

    // R9 clear
    @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    exp_flag = 1'b0;
    check("R9 flag cleared", {15'd0, cap_flag}, 16'd0);
    check("R9 value kept", cap_value, exp_val);

    // R6 off clears
    set_mode(4'b0101);
    pulse();
    check("R6 precondition flag", {15'd0, cap_flag}, 16'd1);
    set_mode(4'd0);
    check("R6 value cleared", cap_value, 16'd0);
    check("R6 flag cleared", {15'd0, cap_flag}, 16'd0);
    pulse();
    check("R6 no capture while off", {15'd0, cap_flag}, 16'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule